// File: doc/BRIEF.md
# Software-Loaded Paired-Page Translation Table

This block holds a small, fully associative table of address translations. Software loads and inspects it through five staging registers: a virtual-side register, two physical-side registers, a page-size register and an index register. Each table entry maps an even/odd pair of adjacent virtual pages. Each page of the pair has its own physical frame, valid bit, dirty bit and cache attribute. The pair shares one address-space identifier and one page size.

Software fills the staging registers with write strobes and then issues one of four commands on a single strobe:
- a probe, which searches the table for the virtual-side register's tag;
- an indexed write;
- a write at a pseudo-random slot;
- an indexed read, which copies an entry back into the staging registers.

The random slot comes either from an external input or from an internal down-counter. The counter never selects a slot below a software-set floor, so low slots can be pinned. Every command completes in one cycle and reports with a one-cycle `done` pulse.

Top module: `sw_tlb`

## Requirements
- R1: While reset is held, and at its release, every staging register reads zero, `done` is low and `rand_idx` equals ENTRIES-1. Every table entry is cleared, including its valid bits, so an indexed read of any slot returns zeros.
- R2: Staging writes keep only the following bits and clear the rest:
  - `hi_we` keeps bits 31:13 (tag) and 7:0 (address-space identifier).
  - `lo0_we` and `lo1_we` keep bits 29:0. Within them, bit 0 is global, bit 1 valid, bit 2 dirty, bits 5:3 cache attribute and bits 29:6 frame.
  - `mask_we` keeps bits 24:13.
  - `index_we` replaces bits IDX_W-1:0 and clears bits 30:IDX_W, leaving bit 31 unchanged.
  - `wired_we` loads the floor from `wdata[IDX_W-1:0]`.
- R3: `cmd_op` selects the command: 0 probe, 1 indexed write, 2 random write, 3 indexed read. A command accepted at an edge updates its results at that same edge. `done` is high for exactly the following cycle, and only after an accepted command.
- R4: An indexed write stores the current staging contents into slot `index[IDX_W-1:0]`; index bits above that are ignored. The slot receives the tag, the identifier, the page-size field (bits 24:13) and both physical-side words.
- R5: An entry's global flag is the AND of bit 0 of both physical-side staging registers at write time. Any later read returns that flag in bit 0 of both physical-side registers.
- R6: An indexed read of slot `index[IDX_W-1:0]` loads the staging registers as follows:
  - The virtual-side register becomes tag in bits 31:13 and identifier in bits 7:0, with bits 12:8 zero.
  - The page-size register becomes the stored field in bits 24:13.
  - Each physical-side register becomes global | valid<<1 | dirty<<2 | attribute<<3 | frame<<6.
- R7: A probe matches a slot whose tag equals bits 31:13 of the virtual-side register and which is global or holds an equal identifier. On a match, the index register becomes the lowest matching slot number, with all other bits zero.
- R8: A probe with no match sets bit 31 of the index register and leaves its other bits unchanged.
- R9: `rand_idx` steps down by one every cycle. When it is at or below the floor, the next value is ENTRIES-1.
- R10: A random write uses `rand_ext` when `rand_ext_en` is high, otherwise the current `rand_idx` value. Probes and random writes leave the virtual-side, physical-side and page-size registers unchanged.
- R11: Staging-register write strobes are ignored in any cycle in which `cmd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_we | input | 1 | Write virtual-side staging register |
| lo0_we | input | 1 | Write even-page physical staging register |
| lo1_we | input | 1 | Write odd-page physical staging register |
| mask_we | input | 1 | Write page-size staging register |
| index_we | input | 1 | Write index register |
| wired_we | input | 1 | Write random-slot floor |
| wdata | input | 32 | Write data for staging strobes |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code |
| rand_ext_en | input | 1 | Use external random slot |
| rand_ext | input | IDX_W | External random slot |
| hi_q | output | 32 | Virtual-side staging register |
| lo0_q | output | 32 | Even-page physical staging register |
| lo1_q | output | 32 | Odd-page physical staging register |
| mask_q | output | 32 | Page-size staging register |
| index_q | output | 32 | Index register |
| rand_idx | output | IDX_W | Internal random slot counter |
| done | output | 1 | Command completion pulse |

## Verification
Every result of this block is a register loaded at the edge that accepts the command or the staging write. The bench therefore drives inputs on the falling edge and compares all outputs on the next falling edge against a behavioural model, so each check lands one edge after its stimulus. `done` is expected in that same cycle, and `rand_idx` is checked every cycle against a model that steps once per rising edge using the floor held before that edge. Probes are mixed with simultaneous staging writes, so ignored strobes show up as unchanged registers in the next comparison.

// File: rtl/sw_tlb.sv
module sw_tlb #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hi_we,
  input  logic             lo0_we,
  input  logic             lo1_we,
  input  logic             mask_we,
  input  logic             index_we,
  input  logic             wired_we,
  input  logic [31:0]      wdata,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic             rand_ext_en,
  input  logic [IDX_W-1:0] rand_ext,
  output logic [31:0]      hi_q,
  output logic [31:0]      lo0_q,
  output logic [31:0]      lo1_q,
  output logic [31:0]      mask_q,
  output logic [31:0]      index_q,
  output logic [IDX_W-1:0] rand_idx,
  output logic             done
);
  localparam int TOP = ENTRIES - 1;
  localparam logic [1:0] OP_PROBE = 2'd0, OP_WIDX = 2'd1, OP_WRND = 2'd2, OP_READ = 2'd3;

  logic [18:0]        tag_q  [ENTRIES];
  logic [7:0]         asid_q [ENTRIES];
  logic [11:0]        pm_q   [ENTRIES];
  logic [28:0]        p0_q   [ENTRIES];
  logic [28:0]        p1_q   [ENTRIES];
  logic [ENTRIES-1:0] glob_q;
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   wired_q, hit_idx, wsel, ridx;
  logic               hit, do_wr;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = (tag_q[g] == hi_q[31:13]) && (glob_q[g] || asid_q[g] == hi_q[7:0]);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = TOP; i >= 0; i--)
      if (match[i]) hit_idx = IDX_W'(i);
  end

  assign hit   = |match;
  assign ridx  = index_q[IDX_W-1:0];
  assign wsel  = (cmd_op == OP_WRND) ? (rand_ext_en ? rand_ext : rand_idx) : ridx;
  assign do_wr = cmd_valid && (cmd_op == OP_WIDX || cmd_op == OP_WRND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]  <= '0;
        asid_q[i] <= '0;
        pm_q[i]   <= '0;
        p0_q[i]   <= '0;
        p1_q[i]   <= '0;
      end
    end else if (do_wr) begin
      tag_q[wsel]  <= hi_q[31:13];
      asid_q[wsel] <= hi_q[7:0];
      pm_q[wsel]   <= mask_q[24:13];
      p0_q[wsel]   <= lo0_q[29:1];
      p1_q[wsel]   <= lo1_q[29:1];
      glob_q[wsel] <= lo0_q[0] & lo1_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      lo0_q   <= '0;
      lo1_q   <= '0;
      mask_q  <= '0;
      index_q <= '0;
      wired_q <= '0;
    end else if (cmd_valid) begin
      if (cmd_op == OP_PROBE) begin
        if (hit) index_q <= {{(32-IDX_W){1'b0}}, hit_idx};
        else     index_q[31] <= 1'b1;
      end else if (cmd_op == OP_READ) begin
        hi_q   <= {tag_q[ridx], 5'b0, asid_q[ridx]};
        mask_q <= {7'b0, pm_q[ridx], 13'b0};
        lo0_q  <= {2'b0, p0_q[ridx], glob_q[ridx]};
        lo1_q  <= {2'b0, p1_q[ridx], glob_q[ridx]};
      end
    end else begin
      if (hi_we)    hi_q    <= wdata & 32'hFFFF_E0FF;
      if (lo0_we)   lo0_q   <= wdata & 32'h3FFF_FFFF;
      if (lo1_we)   lo1_q   <= wdata & 32'h3FFF_FFFF;
      if (mask_we)  mask_q  <= wdata & 32'h01FF_E000;
      if (index_we) index_q <= {index_q[31], {(31-IDX_W){1'b0}}, wdata[IDX_W-1:0]};
      if (wired_we) wired_q <= wdata[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rand_idx <= IDX_W'(TOP);
      done     <= 1'b0;
    end else begin
      rand_idx <= (rand_idx <= wired_q) ? IDX_W'(TOP) : rand_idx - 1'b1;
      done     <= cmd_valid;
    end
  end

  assert_done_follows_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> done);
  assert_done_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cmd_valid));
  assert_probe_hit_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PROBE && hit) |=> index_q == 32'($past(hit_idx)));
  assert_probe_miss_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PROBE && !hit) |=> index_q[31]);
  assert_read_global_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_READ) |=> lo0_q[0] == lo1_q[0]);
  assert_rand_steps_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rand_idx != IDX_W'(TOP)) |-> (rand_idx + 1'b1) == $past(rand_idx));
  assert_cmd_blocks_writes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op != OP_READ) |=> $stable(hi_q) && $stable(mask_q));
endmodule

// File: tb/sw_tlb_tb_top.sv
module sw_tlb_tb_top;
  localparam int N = 16;
  localparam int IW = 4;

  logic clk = 0, rst_n = 0;
  logic hi_we = 0, lo0_we = 0, lo1_we = 0, mask_we = 0, index_we = 0, wired_we = 0;
  logic [31:0] wdata = 0;
  logic cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic rand_ext_en = 0;
  logic [IW-1:0] rand_ext = 0;
  logic [31:0] hi_q, lo0_q, lo1_q, mask_q, index_q;
  logic [IW-1:0] rand_idx;
  logic done;

  sw_tlb #(.ENTRIES(N)) dut_i (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit started = 0, finished = 0;

  logic [31:0] m_hi, m_lo0, m_lo1, m_mask, m_idx;
  logic [31:0] t_hi [N], t_lo0 [N], t_lo1 [N], t_mask [N];
  int m_rand, m_wired;
  bit m_done;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hi = 0; m_lo0 = 0; m_lo1 = 0; m_mask = 0; m_idx = 0;
      m_rand = N - 1; m_wired = 0; m_done = 0;
      for (int i = 0; i < N; i++) begin t_hi[i] = 0; t_lo0[i] = 0; t_lo1[i] = 0; t_mask[i] = 0; end
    end else begin
      int old_r, slot, found;
      bit g;
      old_r = m_rand;
      m_rand = (old_r <= m_wired) ? N - 1 : old_r - 1;
      m_done = cmd_valid;
      if (cmd_valid) begin
        case (cmd_op)
          2'd0: begin
            found = -1;
            for (int i = 0; i < N; i++)
              if (found < 0 && t_hi[i][31:13] == m_hi[31:13] &&
                  ((t_lo0[i][0] & t_lo1[i][0]) || t_hi[i][7:0] == m_hi[7:0])) found = i;
            if (found >= 0) m_idx = found; else m_idx = m_idx | 32'h8000_0000;
          end
          2'd1, 2'd2: begin
            slot = (cmd_op == 2'd1) ? int'(m_idx % N) : (rand_ext_en ? int'(rand_ext) : old_r);
            t_hi[slot] = m_hi; t_lo0[slot] = m_lo0; t_lo1[slot] = m_lo1; t_mask[slot] = m_mask;
          end
          default: begin
            slot = int'(m_idx % N);
            g = t_lo0[slot][0] & t_lo1[slot][0];
            m_hi = t_hi[slot]; m_mask = t_mask[slot];
            m_lo0 = {t_lo0[slot][31:1], g};
            m_lo1 = {t_lo1[slot][31:1], g};
          end
        endcase
      end else begin
        if (hi_we)    m_hi = wdata & 32'hFFFF_E0FF;
        if (lo0_we)   m_lo0 = wdata & 32'h3FFF_FFFF;
        if (lo1_we)   m_lo1 = wdata & 32'h3FFF_FFFF;
        if (mask_we)  m_mask = wdata & 32'h01FF_E000;
        if (index_we) m_idx = (m_idx & 32'h8000_0000) | (wdata % N);
        if (wired_we) m_wired = int'(wdata % N);
      end
    end
    started = 1;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (started && !finished) begin
    string tag;
    tag = rst_n ? "R3" : "R1";
    chk(tag, "done", 32'(done), 32'(m_done));
    chk(rst_n ? "R2 R6" : "R1", "hi", hi_q, m_hi);
    chk(rst_n ? "R5 R6" : "R1", "lo0", lo0_q, m_lo0);
    chk(rst_n ? "R5 R6" : "R1", "lo1", lo1_q, m_lo1);
    chk(rst_n ? "R2 R6" : "R1", "mask", mask_q, m_mask);
    chk(rst_n ? "R4 R7 R8" : "R1", "index", index_q, m_idx);
    chk(rst_n ? "R9" : "R1", "rand", 32'(rand_idx), 32'(m_rand));
  end

  task automatic drive_idle();
    hi_we = 0; lo0_we = 0; lo1_we = 0; mask_we = 0; index_we = 0; wired_we = 0;
    cmd_valid = 0; wdata = $urandom;
  endtask

  task automatic reg_wr(int sel, logic [31:0] d);
    @(negedge clk); drive_idle(); wdata = d;
    case (sel)
      0: hi_we = 1; 1: lo0_we = 1; 2: lo1_we = 1; 3: mask_we = 1; 4: index_we = 1; default: wired_we = 1;
    endcase
  endtask

  // with_writes exercises R11: strobes raised alongside a command must be dropped
  task automatic do_cmd(logic [1:0] op, bit with_writes);
    @(negedge clk); drive_idle();
    cmd_valid = 1; cmd_op = op;
    if (with_writes) begin hi_we = 1; mask_we = 1; index_we = 1; wired_we = 1; end
  endtask

  task automatic load_and_write(int slot, logic [31:0] hi, bit glob);
    logic [31:0] a, b;
    a = $urandom; b = $urandom;
    if (glob) begin a[0] = 1; b[0] = 1; end
    reg_wr(0, hi); reg_wr(1, a); reg_wr(2, b); reg_wr(3, $urandom);
    reg_wr(4, {$urandom} & 32'h7FFF_FFF0 | 32'(slot));
    do_cmd(2'd1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    do_cmd(2'd3, 0);                 // R1: cleared slot 0 reads back zero
    reg_wr(4, 32'd9); do_cmd(2'd3, 0);
    reg_wr(5, 32'd3);                // R9 floor
    for (int i = 0; i < N; i++)      // R4 R5: duplicate tags every 6 slots
      load_and_write(i, {19'(16'h100 + i % 6), 5'h1F, 8'(i * 7)}, (i % 4) == 1);
    reg_wr(0, 32'h0); reg_wr(1, 32'h1); reg_wr(2, 32'h3); reg_wr(4, 32'h35); do_cmd(2'd1, 0);
    for (int k = 0; k < N; k++) begin reg_wr(4, 32'(k) | 32'hF0); do_cmd(2'd3, 0); end
    for (int k = 0; k < 40; k++) begin   // R7 R8
      logic [31:0] h;
      h = {19'(16'h100 + k % 8), 5'h0, 8'((k % 6) * 7 + (k % 3))};
      if (k % 5 == 4) h = $urandom;
      reg_wr(0, h); do_cmd(2'd0, k % 3 == 0);
      if (k % 7 == 0) do_cmd(2'd0, 0);
    end
    for (int k = 0; k < 20; k++) begin   // R10
      rand_ext_en = (k % 2 == 0); rand_ext = IW'($urandom);
      reg_wr(0, $urandom); reg_wr(1, $urandom); repeat (k % 3) reg_wr(3, $urandom);
      do_cmd(2'd2, 0);
      reg_wr(0, $urandom); do_cmd(2'd0, 0);
    end
    rand_ext_en = 0;
    reg_wr(5, 32'd15); repeat (4) begin @(negedge clk); drive_idle(); end
    reg_wr(5, 32'd0); repeat (20) begin @(negedge clk); drive_idle(); end
    reg_wr(5, 32'd10); repeat (8) begin @(negedge clk); drive_idle(); end
    for (int k = 0; k < N; k++) begin reg_wr(4, 32'(k)); do_cmd(2'd3, 0); end
    @(negedge clk); drive_idle();
    @(negedge clk); @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule